// File: doc/BRIEF.md
# Low-Order Interleaved Memory Bank Router

This block is a memory front end. It spreads word addresses over a set of one-word-wide banks by low-order interleaving, so that the word at address `a` sits in bank `a mod NUM_BANKS`. The bank is taken straight from the low address bits, because the bank count is a power of two. A requester asks for a block of 1, 2 or 4 words. The block start is aligned down to the block size. The row part of the address goes to every bank that holds a word of the block in the same cycle, so all their accesses overlap. The words are then handed back one by one over a single-word return path.

The cost of a block is one address phase (4 cycles), one shared bank access (24 cycles) and one transfer slot of 4 cycles for each word. A 4-word block therefore finishes 44 cycles after acceptance, where a non-interleaved memory would take one full access per word. The bank contents are modelled as read-only arrays that are filled at reset with a fixed pattern. Only one block is in flight at a time.

Top module: `ilv_mem_router`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `req_ready_o` is 1 and `word_valid_o`, `block_done_o` and `bank_strobe_o` are 0.
- R2: Bank b holds exactly the addresses with `a mod 4 == b`. The strobe of a block has bit b set for each bank that holds one of its words: bit `addr[1:0]` for 1 word, the two banks of the 2-aligned pair for 2 words, and all four banks for 4 words.
- R3: The strobe bits of all involved banks rise together for exactly one cycle, 4 cycles after the acceptance edge. No strobe appears at any other time.
- R4: Word k (k from 0) of a block of N words is presented for exactly one cycle, 28 + 4·(k+1) cycles after the acceptance edge. No word is presented at any other time.
- R5: Words return in ascending address order, starting at the request address with its low log2(N) bits cleared. `word_addr_o` carries the address of each word.
- R6: The word at address a has the value `(a*37) xor 0x5A5A`, truncated to 32 bits.
- R7: `block_done_o` is 1 together with the last word of a block and at no other time.
- R8: `req_ready_o` is 0 from the acceptance edge until the cycle of the last word. A request made while it is 0 is ignored and produces no strobes and no words.
- R9: Length code 3 is invalid and the request is ignored. Codes 0, 1 and 2 mean 1, 2 and 4 words.
- R10: `req_ready_o` is 1 in the cycle of the last word, so a request held at that edge is accepted back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Block read request |
| req_addr_i | input | ADDR_W | Word address of the request |
| req_len_i | input | LEN_W | Length code: 0 = 1 word, 1 = 2 words, 2 = 4 words |
| req_ready_o | output | 1 | Router idle, able to accept a request |
| bank_strobe_o | output | NUM_BANKS | One-cycle access start, one bit per bank |
| word_valid_o | output | 1 | A returned word is present |
| word_addr_o | output | ADDR_W | Address of the returned word |
| word_data_o | output | DATA_W | Returned word |
| block_done_o | output | 1 | Marks the last word of a block |

## Verification
The bench targets unaligned request addresses, where a design that skipped the alignment would return the wrong first word or strobe the wrong pair of banks. It also uses the topmost block of the address space, where a carry in the word counter would wrap into the wrong bank. It times every strobe and word to the exact cycle, which catches a design that charges one access per word or loses a cycle between the bank access and the first transfer slot. Requests made while a block is in flight, requests with the invalid length code, and a request held across the final word are each checked: a wrong design would start a stray block, lose the chained request, or accept it one cycle late.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACC,
    ST_XFER
  } seq_state_e;

  // fixed bank fill pattern, read-only storage model
  function automatic logic [31:0] fill_word(input int unsigned a);
    return 32'(a * 37) ^ 32'h0000_5A5A;
  endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int DATA_W    = 32,
  parameter int ROW_W     = 6,
  parameter int NUM_BANKS = 4,
  parameter int BANK_ID   = 0,
  parameter int ACC_CYC   = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  import ilv_pkg::*;

  localparam int DEPTH    = 1 << ROW_W;
  localparam int CNT_W    = $clog2(ACC_CYC + 1);
  localparam int ACC_LOAD = (ACC_CYC > 2) ? ACC_CYC - 2 : 0;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < DEPTH; j++) begin
        mem_q[j] <= DATA_W'(fill_word(32'(j * NUM_BANKS + BANK_ID)));
      end
    end
  end

  // strobe cycle counts as the first access cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else if (strobe_i) begin
      busy_q     <= 1'b1;
      cnt_q      <= CNT_W'(ACC_LOAD);
      rd_valid_o <= 1'b0;
      rd_data_o  <= mem_q[row_i];
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q     <= 1'b0;
        rd_valid_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/ilv_seq.sv
module ilv_seq #(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 4,
  parameter int LEN_W     = 2,
  parameter int ADDR_CYC  = 4,
  parameter int XFER_CYC  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [LEN_W-1:0]     req_len_i,
  input  logic [NUM_BANKS-1:0] rd_valid_i,
  output logic                 req_ready_o,
  output logic [NUM_BANKS-1:0] strobe_o,
  output logic [ADDR_W-$clog2(NUM_BANKS)-1:0] row_o,
  output logic                 word_valid_o,
  output logic [ADDR_W-1:0]    word_addr_o,
  output logic                 block_done_o
);
  import ilv_pkg::*;

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int CMAX   = (ADDR_CYC > XFER_CYC) ? ADDR_CYC : XFER_CYC;
  localparam int CNT_W  = $clog2(CMAX + 1);
  localparam int XLOAD0 = (XFER_CYC > 2) ? XFER_CYC - 2 : 0;

  seq_state_e          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [ADDR_W-1:0]   base_q;
  logic [BANK_W-1:0]   widx_q, last_q;
  logic [NUM_BANKS-1:0] mask_q;

  logic                len_ok;
  logic [BANK_W:0]     nwords;
  logic [ADDR_W-1:0]   base_d;
  logic [NUM_BANKS-1:0] mask_d;
  logic                all_ready;

  assign len_ok = (int'(req_len_i) <= BANK_W);
  assign nwords = (BANK_W+1)'(1) << req_len_i;
  assign base_d = req_addr_i & ({ADDR_W{1'b1}} << req_len_i);

  // bank b is involved when its distance from the aligned base is below the length
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      logic [BANK_W-1:0] off;
      off       = BANK_W'(b) - base_d[BANK_W-1:0];
      mask_d[b] = ({1'b0, off} < nwords);
    end
  end

  assign all_ready   = &(rd_valid_i | ~mask_q);
  assign req_ready_o = (state_q == ST_IDLE);
  assign row_o       = base_q[ADDR_W-1:BANK_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      base_q       <= '0;
      widx_q       <= '0;
      last_q       <= '0;
      mask_q       <= '0;
      strobe_o     <= '0;
      word_valid_o <= 1'b0;
      word_addr_o  <= '0;
      block_done_o <= 1'b0;
    end else begin
      strobe_o     <= '0;
      word_valid_o <= 1'b0;
      block_done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i && len_ok) begin
            base_q  <= base_d;
            last_q  <= BANK_W'(nwords - 1'b1);
            mask_q  <= mask_d;
            widx_q  <= '0;
            cnt_q   <= CNT_W'(ADDR_CYC - 1);
            state_q <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (cnt_q == '0) begin
            strobe_o <= mask_q;
            state_q  <= ST_ACC;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_ACC: begin
          // bank valid flags are stale until the strobe cycle has passed
          if (strobe_o == '0 && all_ready) begin
            cnt_q   <= CNT_W'(XLOAD0);
            state_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (cnt_q == '0) begin
            word_valid_o <= 1'b1;
            word_addr_o  <= base_q + ADDR_W'(widx_q);
            if (widx_q == last_q) begin
              block_done_o <= 1'b1;
              state_q      <= ST_IDLE;
            end else begin
              widx_q <= widx_q + 1'b1;
              cnt_q  <= CNT_W'(XFER_CYC - 1);
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ilv_mem_router.sv
module ilv_mem_router #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 4,
  parameter int ADDR_CYC  = 4,
  parameter int ACC_CYC   = 24,
  parameter int XFER_CYC  = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = ADDR_W - BANK_W,
  localparam int LEN_W    = $clog2(BANK_W + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [LEN_W-1:0]     req_len_i,
  output logic                 req_ready_o,
  output logic [NUM_BANKS-1:0] bank_strobe_o,
  output logic                 word_valid_o,
  output logic [ADDR_W-1:0]    word_addr_o,
  output logic [DATA_W-1:0]    word_data_o,
  output logic                 block_done_o
);

  logic [ROW_W-1:0]     row;
  logic [NUM_BANKS-1:0] rd_valid;
  logic [DATA_W-1:0]    rd_data [NUM_BANKS];

  ilv_seq #(
    .ADDR_W   (ADDR_W),
    .NUM_BANKS(NUM_BANKS),
    .LEN_W    (LEN_W),
    .ADDR_CYC (ADDR_CYC),
    .XFER_CYC (XFER_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .req_len_i   (req_len_i),
    .rd_valid_i  (rd_valid),
    .req_ready_o (req_ready_o),
    .strobe_o    (bank_strobe_o),
    .row_o       (row),
    .word_valid_o(word_valid_o),
    .word_addr_o (word_addr_o),
    .block_done_o(block_done_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ilv_bank #(
      .DATA_W   (DATA_W),
      .ROW_W    (ROW_W),
      .NUM_BANKS(NUM_BANKS),
      .BANK_ID  (b),
      .ACC_CYC  (ACC_CYC)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .strobe_i  (bank_strobe_o[b]),
      .row_i     (row),
      .rd_valid_o(rd_valid[b]),
      .rd_data_o (rd_data[b])
    );
  end

  // bank data is held until the next strobe, so select by returned address
  assign word_data_o = rd_data[word_addr_o[BANK_W-1:0]];

endmodule

// File: rtl/ilv_mem_router_chk.sv
module ilv_mem_router_chk #(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 4,
  parameter int ADDR_CYC  = 4,
  parameter int ACC_CYC   = 24,
  parameter int XFER_CYC  = 4,
  parameter int LEN_W     = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic [LEN_W-1:0]     req_len_i,
  input logic                 req_ready_o,
  input logic [NUM_BANKS-1:0] bank_strobe_o,
  input logic                 word_valid_o,
  input logic                 block_done_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic             accept;
  logic [15:0]      cyc_q;
  logic [BANK_W:0]  widx_q;
  logic [LEN_W-1:0] len_q;

  assign accept = req_valid_i && req_ready_o && (int'(req_len_i) <= BANK_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      widx_q <= '0;
      len_q  <= '0;
    end else if (accept) begin
      cyc_q  <= '0;
      widx_q <= '0;
      len_q  <= req_len_i;
    end else begin
      if (cyc_q != 16'hFFFF) cyc_q <= cyc_q + 1'b1;
      if (word_valid_o) widx_q <= widx_q + 1'b1;
    end
  end

  // R7
  done_with_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_done_o |-> word_valid_o);

  // R3
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bank_strobe_o) |=> (bank_strobe_o == '0));

  // R3
  strobe_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bank_strobe_o) |-> (int'(cyc_q) == ADDR_CYC));

  // R2
  strobe_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bank_strobe_o) |-> ($countones(bank_strobe_o) == (1 << len_q)));

  // R4
  word_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (int'(cyc_q) == ADDR_CYC + ACC_CYC + XFER_CYC * (int'(widx_q) + 1)));

  // R4
  word_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !block_done_o) |=> !word_valid_o);

  // R8
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !block_done_o) |-> !req_ready_o);

  // R10
  ready_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_done_o |-> req_ready_o);

  // R9
  bad_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && int'(req_len_i) > BANK_W) |=> req_ready_o);

endmodule

bind ilv_mem_router ilv_mem_router_chk #(
  .ADDR_W   (ADDR_W),
  .NUM_BANKS(NUM_BANKS),
  .ADDR_CYC (ADDR_CYC),
  .ACC_CYC  (ACC_CYC),
  .XFER_CYC (XFER_CYC),
  .LEN_W    (LEN_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_len_i    (req_len_i),
  .req_ready_o  (req_ready_o),
  .bank_strobe_o(bank_strobe_o),
  .word_valid_o (word_valid_o),
  .block_done_o (block_done_o)
);

// File: tb/ilv_mem_router_test.sv
module ilv_mem_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int T_ADDR = 4;
  localparam int T_ACC  = 24;
  localparam int T_XFER = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_len = '0;
  logic        req_ready;
  logic [3:0]  bank_strobe;
  logic        word_valid;
  logic [7:0]  word_addr;
  logic [31:0] word_data;
  logic        block_done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_mem_router uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid),
    .req_addr_i   (req_addr),
    .req_len_i    (req_len),
    .req_ready_o  (req_ready),
    .bank_strobe_o(bank_strobe),
    .word_valid_o (word_valid),
    .word_addr_o  (word_addr),
    .word_data_o  (word_data),
    .block_done_o (block_done)
  );

  function automatic logic [31:0] exp_word(input int a);
    return 32'(a * 37) ^ 32'h0000_5A5A;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // one block; pre=1 when the request was driven by the previous block's chain
  task automatic run_block(input int addr, input int len_code, input bit pre,
                           input bit poke, input bit chain, input int naddr,
                           input int nlen);
    int n, base, last, strobe_err, stray_err, ready_err;
    logic [3:0] exp_mask;
    n = 1 << len_code;
    base = addr & ~(n - 1);
    last = T_ADDR + T_ACC + T_XFER * n;
    exp_mask = '0;
    for (int k = 0; k < n; k++) exp_mask[(base + k) % 4] = 1'b1;
    strobe_err = 0; stray_err = 0; ready_err = 0;
    if (!pre) begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = 8'(addr); req_len = 2'(len_code);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R8", "ready after accept", req_ready, 0);
    for (int c = 1; c <= last; c++) begin
      @(negedge clk);
      if (c == T_ADDR)
        check(bank_strobe == exp_mask, "R2", "strobe mask", bank_strobe, exp_mask);
      else if (bank_strobe != 0) strobe_err++;
      if (c > T_ADDR + T_ACC && (c - T_ADDR - T_ACC) % T_XFER == 0) begin
        int k;
        k = (c - T_ADDR - T_ACC) / T_XFER - 1;
        check(word_valid, "R4", "word timing", word_valid, 1);
        check(word_addr == 8'(base + k), "R5", "word order", word_addr, base + k);
        check(word_data == exp_word(base + k), "R6", "word data", word_data,
              exp_word(base + k));
        check(block_done == (k == n - 1), "R7", "done flag", block_done, k == n - 1);
      end else if (word_valid || block_done) stray_err++;
      if (c < last && req_ready) ready_err++;
      if (poke && c == 10) begin
        req_valid = 1'b1; req_addr = 8'(addr ^ 8'h40); req_len = 2'd0;
      end
      if (poke && c == 11) req_valid = 1'b0;
    end
    check(req_ready, "R10", "ready at last word", req_ready, 1);
    check(strobe_err == 0, "R3", "stray strobe cycles", strobe_err, 0);
    check(stray_err == 0, "R4", "stray word cycles", stray_err, 0);
    check(ready_err == 0, "R8", "ready while busy", ready_err, 0);
    if (chain) begin
      req_valid = 1'b1; req_addr = 8'(naddr); req_len = 2'(nlen);
    end
  endtask

  task automatic quiet_window(input string req, input int cycles);
    int bad;
    bad = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (bank_strobe != 0 || word_valid || block_done || !req_ready) bad++;
    end
    check(bad == 0, req, "idle after ignored request", bad, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(req_ready && !word_valid && !block_done && bank_strobe == 0, "R1",
          "outputs in reset", {req_ready, word_valid, block_done, bank_strobe}, 7'b1000000);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(req_ready && !word_valid && !block_done && bank_strobe == 0, "R1",
          "outputs after reset", {req_ready, word_valid, block_done, bank_strobe}, 7'b1000000);
  endtask

  task automatic t_bad_len;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 8'h21; req_len = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    quiet_window("R9", 50);
  endtask

  task automatic t_busy_poke;
    run_block(8'h13, 2, 1'b0, 1'b1, 1'b0, 0, 0);
    quiet_window("R8", 50);
  endtask

  task automatic t_chain;
    run_block(8'h3C, 1, 1'b0, 1'b0, 1'b1, 8'hFF, 2);
    run_block(8'hFF, 2, 1'b1, 1'b0, 1'b0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    t_reset();
    run_block(8'h05, 0, 1'b0, 1'b0, 1'b0, 0, 0);  // single word, bank 1
    run_block(8'h2B, 1, 1'b0, 1'b0, 1'b0, 0, 0);  // unaligned pair, banks 2,3
    run_block(8'h77, 2, 1'b0, 1'b0, 1'b0, 0, 0);  // unaligned quad
    run_block(8'h00, 2, 1'b0, 1'b0, 1'b0, 0, 0);  // aligned quad at zero
    t_busy_poke();
    t_bad_len();
    t_chain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule